// File: doc/BRIEF.md
# SPI Chip-Select and Mode-Fault Controller

This block owns the chip-select line of an SPI port and the enable and master state bits that depend on it. It decides, from the control inputs, where the select level comes from. The select can be driven onto the pin by hardware while the port is a master. It can be taken from the pin as an input, through a synchronizer. Or it can be taken from a level that software writes, with the pin ignored. The shift engine sits outside the block. That engine reports its activity on `xfer_busy` and reads back `spi_en`, `mst_en` and `slave_sel`.

When the port is a master that takes its select as an input, a low select means that another master has claimed the bus. The same holds for a software level of 0. The block then clears the enable, drops to slave mode and sets a sticky mode-error flag. While that flag is set, control writes cannot set the enable or master bits. The flag is cleared by an access to the status register and a later write to the control register. An error interrupt follows the flag, gated by its enable.

Top module: `spi_csel_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `spi_en`, `mst_en`, `mode_err`, `err_irq`, `slave_sel` and `cs_pin_oe` are 0 and `cs_pin_o` is 1.
- R2: With `mode_err` at 0, a cycle with `ctrl_wr`=1 loads `wr_spi_en` into `spi_en` and `wr_mst_en` into `mst_en` at that clock edge.
- R3: In master output mode (`mst_en`=1, `hw_out_en`=1, `sw_sel_en`=0), `cs_pin_oe`=1 and `cs_pin_o`=0 from one cycle after `spi_en` becomes 1.
- R4: In master output mode, once the pin is driven it stays driven while `xfer_busy`=1, even with `spi_en` at 0. It is released (`cs_pin_oe`=0, `cs_pin_o`=1) one cycle after `spi_en`=0 and `xfer_busy`=0 are both seen.
- R5: With `mst_en`=1, `hw_out_en`=0 and `sw_sel_en`=0, a low on `cs_pin_i` passes a two-stage synchronizer. At the third clock edge after the pin falls, `mode_err` becomes 1 and `spi_en` and `mst_en` become 0.
- R6: With `mst_en`=1 and `sw_sel_en`=1, `sw_sel_lvl`=0 sets `mode_err` and clears `spi_en` and `mst_en` at the next clock edge.
- R7: `err_irq` equals `mode_err` AND `err_ie` as sampled one cycle earlier.
- R8: While `mode_err`=1, control writes cannot set `spi_en` or `mst_en`; both stay 0.
- R9: `mode_err` is cleared only by a `ctrl_wr` that comes after a `sts_acc` seen while the flag was set. Idle cycles between the two do not cancel the armed clear. A `ctrl_wr` without that earlier status access leaves the flag set. The clearing write itself cannot set `spi_en` or `mst_en`.
- R10: In slave mode (`mst_en`=0) with `sw_sel_en`=0, `slave_sel` becomes 1 at the third clock edge after `cs_pin_i` falls, and returns to 0 the same way after it rises.
- R11: In slave mode with `sw_sel_en`=1, `slave_sel` is the inverse of `sw_sel_lvl` one cycle later, whatever `cs_pin_i` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_wr | input | 1 | Write strobe for the control register |
| wr_spi_en | input | 1 | Enable bit value carried by a control write |
| wr_mst_en | input | 1 | Master bit value carried by a control write |
| hw_out_en | input | 1 | Drive the select pin from hardware as master |
| sw_sel_en | input | 1 | Judge select from the software level instead of the pin |
| sw_sel_lvl | input | 1 | Software select level, 0 means selected |
| err_ie | input | 1 | Error interrupt enable |
| sts_acc | input | 1 | Read or write strobe of the status register |
| xfer_busy | input | 1 | Shift engine has a transfer in flight |
| cs_pin_i | input | 1 | Select pin input level |
| cs_pin_o | output | 1 | Select pin output level |
| cs_pin_oe | output | 1 | Select pin output enable |
| spi_en | output | 1 | SPI enable state |
| mst_en | output | 1 | Master mode state |
| mode_err | output | 1 | Sticky multi-master mode-error flag |
| slave_sel | output | 1 | Slave currently selected for transfers |
| err_irq | output | 1 | Error interrupt |

## Verification
The hardest states to reach are the clear sequence and its near misses. The bench must first cause a fault. It then must show that a bare control write leaves the flag set and cannot set the enable bits. Finally it must arm with a status access, wait idle cycles, and clear with a write whose own enable bits are still refused. The pin-driven fault is reached by raising master mode with the pin high and then dropping the pin. The bench counts edges through the synchronizer so that it can check both the last cycle without the fault and the first cycle with it.

// File: rtl/spi_csel_pkg.sv
package spi_csel_pkg;

  typedef enum logic [1:0] {
    SRC_PIN_IN  = 2'd0,
    SRC_PIN_OUT = 2'd1,
    SRC_SOFT    = 2'd2
  } sel_src_e;

  function automatic sel_src_e pick_src(input logic sw_en, input logic hw_oe);
    if (sw_en)      return SRC_SOFT;
    else if (hw_oe) return SRC_PIN_OUT;
    else            return SRC_PIN_IN;
  endfunction

endpackage

// File: rtl/csel_sync.sv
module csel_sync #(
  parameter int STAGES    = 2,
  parameter bit RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= RESET_VAL;
          else     chain_q[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[i] <= RESET_VAL;
          else     chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/csel_fault.sv
module csel_fault (
  input  logic clk,
  input  logic rst,
  input  logic ctrl_wr,
  input  logic wr_spi_en,
  input  logic wr_mst_en,
  input  logic sts_acc,
  input  logic fault_cond,
  input  logic err_ie,
  output logic spi_en_q,
  output logic mst_en_q,
  output logic mode_err_q,
  output logic err_irq_q
);
  logic armed_q;
  logic fault_hit;

  assign fault_hit = mst_en_q && fault_cond;

  always_ff @(posedge clk) begin
    if (rst) begin
      spi_en_q   <= 1'b0;
      mst_en_q   <= 1'b0;
      mode_err_q <= 1'b0;
      armed_q    <= 1'b0;
    end else if (fault_hit) begin
      spi_en_q   <= 1'b0;
      mst_en_q   <= 1'b0;
      mode_err_q <= 1'b1;
      armed_q    <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        if (mode_err_q) begin
          spi_en_q <= spi_en_q & wr_spi_en;
          mst_en_q <= mst_en_q & wr_mst_en;
          if (armed_q) mode_err_q <= 1'b0;
          armed_q <= 1'b0;
        end else begin
          spi_en_q <= wr_spi_en;
          mst_en_q <= wr_mst_en;
        end
      end else if (sts_acc && mode_err_q) begin
        armed_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) err_irq_q <= 1'b0;
    else     err_irq_q <= mode_err_q & err_ie;
  end

  // R8: enable and master stay off for the whole life of the flag
  a_r8_locked: assert property (@(posedge clk) disable iff (rst)
    mode_err_q |-> (!spi_en_q && !mst_en_q));

  // R5 / R6: a qualified fault demotes at the next edge
  a_r6_demote: assert property (@(posedge clk) disable iff (rst)
    (mst_en_q && fault_cond) |=> (mode_err_q && !mst_en_q && !spi_en_q));

  // R9: the flag only falls after an armed control write
  a_r9_clear_seq: assert property (@(posedge clk) disable iff (rst)
    $fell(mode_err_q) |-> ($past(ctrl_wr) && $past(armed_q)));

  // R7: interrupt follows the gated flag by one cycle
  a_r7_irq: assert property (@(posedge clk) disable iff (rst)
    err_irq_q |-> $past(mode_err_q && err_ie));
endmodule

// File: rtl/csel_drive.sv
module csel_drive
  import spi_csel_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     spi_en,
  input  logic     mst_en,
  input  sel_src_e src,
  input  logic     xfer_busy,
  input  logic     pin_sync,
  input  logic     sw_sel_lvl,
  output logic     cs_pin_o,
  output logic     cs_pin_oe,
  output logic     slave_sel
);
  logic master_out;
  logic drive_q;
  logic drive_d;
  logic sel_d;

  assign master_out = mst_en && (src == SRC_PIN_OUT);

  always_comb begin
    drive_d = drive_q;
    if (!master_out)     drive_d = 1'b0;
    else if (spi_en)     drive_d = 1'b1;
    else if (!xfer_busy) drive_d = 1'b0;
  end

  always_comb begin
    if (mst_en)               sel_d = 1'b0;
    else if (src == SRC_SOFT) sel_d = !sw_sel_lvl;
    else                      sel_d = !pin_sync;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      drive_q   <= 1'b0;
      cs_pin_oe <= 1'b0;
      cs_pin_o  <= 1'b1;
      slave_sel <= 1'b0;
    end else begin
      drive_q   <= drive_d;
      cs_pin_oe <= drive_d;
      cs_pin_o  <= !drive_d;
      slave_sel <= sel_d;
    end
  end

  // R3: enabled master output drives the pin low next cycle
  a_r3_drive: assert property (@(posedge clk) disable iff (rst)
    (master_out && spi_en) |=> (cs_pin_oe && !cs_pin_o));

  // R4: a busy transfer keeps the pin driven
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (cs_pin_oe && master_out && xfer_busy) |=> cs_pin_oe);

  // R10 / R11: a master is never reported as a selected slave
  a_r10_no_sel_master: assert property (@(posedge clk) disable iff (rst)
    mst_en |=> !slave_sel);
endmodule

// File: rtl/spi_csel_ctrl.sv
module spi_csel_ctrl
  import spi_csel_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ctrl_wr,
  input  logic wr_spi_en,
  input  logic wr_mst_en,
  input  logic hw_out_en,
  input  logic sw_sel_en,
  input  logic sw_sel_lvl,
  input  logic err_ie,
  input  logic sts_acc,
  input  logic xfer_busy,
  input  logic cs_pin_i,
  output logic cs_pin_o,
  output logic cs_pin_oe,
  output logic spi_en,
  output logic mst_en,
  output logic mode_err,
  output logic slave_sel,
  output logic err_irq
);
  sel_src_e src;
  logic     pin_sync;
  logic     fault_cond;

  assign src = pick_src(sw_sel_en, hw_out_en);
  assign fault_cond = ((src == SRC_SOFT)   && !sw_sel_lvl) ||
                      ((src == SRC_PIN_IN) && !pin_sync);

  csel_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (cs_pin_i),
    .q   (pin_sync)
  );

  csel_fault u_fault (
    .clk        (clk),
    .rst        (rst),
    .ctrl_wr    (ctrl_wr),
    .wr_spi_en  (wr_spi_en),
    .wr_mst_en  (wr_mst_en),
    .sts_acc    (sts_acc),
    .fault_cond (fault_cond),
    .err_ie     (err_ie),
    .spi_en_q   (spi_en),
    .mst_en_q   (mst_en),
    .mode_err_q (mode_err),
    .err_irq_q  (err_irq)
  );

  csel_drive u_drive (
    .clk        (clk),
    .rst        (rst),
    .spi_en     (spi_en),
    .mst_en     (mst_en),
    .src        (src),
    .xfer_busy  (xfer_busy),
    .pin_sync   (pin_sync),
    .sw_sel_lvl (sw_sel_lvl),
    .cs_pin_o   (cs_pin_o),
    .cs_pin_oe  (cs_pin_oe),
    .slave_sel  (slave_sel)
  );

  // R1: outputs idle on the first cycle after reset
  a_r1_reset_idle: assert property (@(posedge clk)
    $fell(rst) |-> (!spi_en && !mst_en && !mode_err && !cs_pin_oe && cs_pin_o));
endmodule

// File: tb/spi_csel_ctrl_tb.sv
module spi_csel_ctrl_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ctrl_wr = 0, wr_spi_en = 0, wr_mst_en = 0;
  logic hw_out_en = 0, sw_sel_en = 0, sw_sel_lvl = 1, err_ie = 0;
  logic sts_acc = 0, xfer_busy = 0, cs_pin_i = 1;
  logic cs_pin_o, cs_pin_oe, spi_en, mst_en, mode_err, slave_sel, err_irq;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  spi_csel_ctrl u_dut (
    .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .wr_spi_en(wr_spi_en),
    .wr_mst_en(wr_mst_en), .hw_out_en(hw_out_en), .sw_sel_en(sw_sel_en),
    .sw_sel_lvl(sw_sel_lvl), .err_ie(err_ie), .sts_acc(sts_acc),
    .xfer_busy(xfer_busy), .cs_pin_i(cs_pin_i), .cs_pin_o(cs_pin_o),
    .cs_pin_oe(cs_pin_oe), .spi_en(spi_en), .mst_en(mst_en),
    .mode_err(mode_err), .slave_sel(slave_sel), .err_irq(err_irq)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; ctrl_wr = 0; wr_spi_en = 0; wr_mst_en = 0; hw_out_en = 0;
    sw_sel_en = 0; sw_sel_lvl = 1; err_ie = 0; sts_acc = 0; xfer_busy = 0;
    cs_pin_i = 1;
    tick(3);
    rst = 0;
  endtask

  task automatic wr_ctrl(input logic en, input logic ms);
    ctrl_wr = 1; wr_spi_en = en; wr_mst_en = ms;
    tick(1);
    ctrl_wr = 0; wr_spi_en = 0; wr_mst_en = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 spi_en", spi_en, 0);
    chk("R1 mst_en", mst_en, 0);
    chk("R1 mode_err", mode_err, 0);
    chk("R1 err_irq", err_irq, 0);
    chk("R1 slave_sel", slave_sel, 0);
    chk("R1 cs_pin_oe", cs_pin_oe, 0);
    chk("R1 cs_pin_o", cs_pin_o, 1);
  endtask

  task automatic t_master_out();
    do_reset();
    hw_out_en = 1;
    wr_ctrl(1, 1);
    chk("R2 spi_en load", spi_en, 1);
    chk("R2 mst_en load", mst_en, 1);
    chk("R3 oe not yet", cs_pin_oe, 0);
    tick(1);
    chk("R3 oe driven", cs_pin_oe, 1);
    chk("R3 pin low", cs_pin_o, 0);
    xfer_busy = 1;
    wr_ctrl(0, 1);
    chk("R2 spi_en cleared", spi_en, 0);
    tick(2);
    chk("R4 held while busy", cs_pin_oe, 1);
    xfer_busy = 0;
    tick(1);
    chk("R4 released oe", cs_pin_oe, 0);
    chk("R4 released pin", cs_pin_o, 1);
  endtask

  task automatic t_soft_fault();
    do_reset();
    sw_sel_en = 1; sw_sel_lvl = 1; err_ie = 1;
    wr_ctrl(1, 1);
    chk("R6 master up", mst_en, 1);
    sw_sel_lvl = 0;
    tick(1);
    chk("R6 flag set", mode_err, 1);
    chk("R6 spi_en cleared", spi_en, 0);
    chk("R6 mst_en cleared", mst_en, 0);
    chk("R7 irq not yet", err_irq, 0);
    tick(1);
    chk("R7 irq raised", err_irq, 1);
    sw_sel_lvl = 1;
    wr_ctrl(1, 1);
    chk("R8 spi_en locked", spi_en, 0);
    chk("R8 mst_en locked", mst_en, 0);
    chk("R9 bare write keeps flag", mode_err, 1);
    sts_acc = 1;
    tick(1);
    sts_acc = 0;
    tick(3);
    chk("R9 status alone keeps flag", mode_err, 1);
    wr_ctrl(1, 1);
    chk("R9 flag cleared", mode_err, 0);
    chk("R9 clearing write locked", spi_en, 0);
    tick(1);
    chk("R7 irq dropped", err_irq, 0);
    wr_ctrl(1, 1);
    chk("R2 enable after clear", spi_en, 1);
  endtask

  task automatic t_pin_fault();
    do_reset();
    err_ie = 1;
    wr_ctrl(1, 1);
    chk("R5 master up", mst_en, 1);
    cs_pin_i = 0;
    tick(2);
    chk("R5 no fault before sync", mode_err, 0);
    chk("R5 master kept", mst_en, 1);
    tick(1);
    chk("R5 flag set", mode_err, 1);
    chk("R5 spi_en cleared", spi_en, 0);
    chk("R5 mst_en cleared", mst_en, 0);
    tick(1);
    chk("R7 irq on", err_irq, 1);
    err_ie = 0;
    tick(1);
    chk("R7 irq gated", err_irq, 0);
    cs_pin_i = 1;
    sts_acc = 1;
    tick(1);
    sts_acc = 0;
    wr_ctrl(0, 0);
    chk("R9 pin fault cleared", mode_err, 0);
  endtask

  task automatic t_slave_hw();
    do_reset();
    tick(3);
    chk("R10 idle high", slave_sel, 0);
    cs_pin_i = 0;
    tick(2);
    chk("R10 not yet", slave_sel, 0);
    tick(1);
    chk("R10 selected", slave_sel, 1);
    cs_pin_i = 1;
    tick(2);
    chk("R10 still selected", slave_sel, 1);
    tick(1);
    chk("R10 deselected", slave_sel, 0);
  endtask

  task automatic t_slave_sw();
    do_reset();
    sw_sel_en = 1; sw_sel_lvl = 0; cs_pin_i = 1;
    tick(1);
    chk("R11 soft select", slave_sel, 1);
    sw_sel_lvl = 1; cs_pin_i = 0;
    tick(4);
    chk("R11 pin ignored", slave_sel, 0);
  endtask

  initial begin
    t_reset();
    t_master_out();
    t_soft_fault();
    t_pin_fault();
    t_slave_hw();
    t_slave_sw();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule